// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block reduces a 48-bit Ethernet destination address to a 6-bit index into a 64-entry hash table and decides whether a frame carrying that address should be accepted. The index is the top six bits of a reflected CRC-32 of the address. The CRC is worked out one address bit per clock, after a single-cycle start request. The 64-entry table reaches the block as two 32-bit words. The upper word holds entries 32 to 63 and the lower word holds entries 0 to 31. While the hash runs, the block also compares the same address against a stored station address, so a frame passes if it matches exactly or if its hash bucket is enabled.

The same engine has a second use, in which it prepares the register contents for the station's own address. In program mode the block returns the two table words with only the station's hash bit set. It also returns the station address packed into two 32-bit words, ready to be written into the registers that hold the table and the station address.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset `busy`, `done`, `accept`, `exactHit`, `hashHit`, `hashIdx`, `progHi`, `progLo`, `physWord0` and `physWord1` are all zero.
- R2: `hashIdx` equals bits 31..26 of a CRC register that starts at 0xFFFFFFFF. The register takes the address bytes in the order `addrIn[47:40]` first and `addrIn[7:0]` last, and takes each byte least significant bit first. For every bit the register shifts right by one, and it is then XORed with 0xEDB88320 when the incoming bit differs from the register's old bit 0.
- R3: A start accepted while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, 48 clock edges after the accepting edge, and `busy` falls on that same edge.
- R4: A `start` raised while `busy` is high has no effect: the running result and its `done` timing are unchanged.
- R5: When a program-mode operation completes, exactly one bit is set across `progHi`/`progLo`. An index of 32 to 63 sets bit (index−32) of `progHi` and clears `progLo`. An index of 0 to 31 sets bit index of `progLo` and clears `progHi`.
- R6: When a program-mode operation completes, `physWord0` holds address bytes 0..3 (`addrIn[47:16]`). `physWord1` holds bytes 4..5 in bits 31..16 and the constant 0x8808 in bits 15..0.
- R7: When a filter-mode operation completes, `exactHit` is 1 exactly when the address equals `stationAddr`, which is sampled on the completing edge.
- R8: When a filter-mode operation completes, `hashHit` is the table bit at the index: bit (index−32) of `tableHi` for 32 to 63, or bit index of `tableLo` otherwise. `accept` is `exactHit` OR `hashHit`.
- R9: A filter-mode operation leaves `progHi`, `progLo`, `physWord0` and `physWord1` unchanged. A program-mode operation clears `accept`, `exactHit` and `hashHit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| progMode | input | 1 | 1 = program mode, 0 = filter mode, captured at start |
| addrIn | input | 48 | Address to hash, captured at start |
| stationAddr | input | 48 | Stored station address for the exact compare |
| tableHi | input | 32 | Hash table entries 32..63 |
| tableLo | input | 32 | Hash table entries 0..31 |
| busy | output | 1 | Serial hash in progress |
| done | output | 1 | One-cycle completion pulse |
| hashIdx | output | 6 | Hash index of the last operation |
| exactHit | output | 1 | Last filter operation matched the station address |
| hashHit | output | 1 | Last filter operation hit an enabled table bit |
| accept | output | 1 | Frame passes the filter |
| progHi | output | 32 | Upper table word with the station bit set |
| progLo | output | 32 | Lower table word with the station bit set |
| physWord0 | output | 32 | Packed address bytes 0..3 |
| physWord1 | output | 32 | Packed address bytes 4..5 and 0x8808 |

## Verification
Every result register loads on the same edge that raises `done`, 48 edges after the edge that accepts `start`. The bench therefore drives `start` at a falling edge and counts 47 falling edges, at which point `done` must still be low. It samples every output at the next falling edge, and the results must hold there until the next completion. Ignored starts are placed in the middle of a run, so that a wrongly accepted request would both shift this timing and change the index.

// File: rtl/addr_hash_pkg.sv
package addr_hash_pkg;
  localparam int ADDR_BITS  = 48;
  localparam int HASH_BITS  = 6;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [15:0] PHYS_TAG = 16'h8808;

  typedef struct packed {
    logic load;
    logic shift;
    logic finish;
  } hashStrobe_t;
endpackage

// File: rtl/hash_ctrl.sv
module hash_ctrl
  import addr_hash_pkg::*;
#(
  parameter int NBITS = ADDR_BITS
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output hashStrobe_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strobes.load   = !busy && start;
    strobes.shift  = busy;
    strobes.finish = busy && (bitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bitCnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          bitCnt <= '0;
        end
      end else begin
        bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy) && !busy);
  // R4
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && bitCnt != LAST) |=> busy && bitCnt == $past(bitCnt) + CNT_W'(1));
endmodule

// File: rtl/hash_datapath.sv
module hash_datapath
  import addr_hash_pkg::*;
#(
  parameter int NBITS = ADDR_BITS,
  parameter int HBITS = HASH_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  hashStrobe_t        strobes,
  input  logic               progMode,
  input  logic [NBITS-1:0]   addrIn,
  input  logic [NBITS-1:0]   stationAddr,
  input  logic [(1<<(HBITS-1))-1:0] tableHi,
  input  logic [(1<<(HBITS-1))-1:0] tableLo,
  output logic [HBITS-1:0]   hashIdx,
  output logic               exactHit,
  output logic               hashHit,
  output logic               accept,
  output logic [(1<<(HBITS-1))-1:0] progHi,
  output logic [(1<<(HBITS-1))-1:0] progLo,
  output logic [31:0]        physWord0,
  output logic [31:0]        physWord1
);
  localparam int HALF_W  = 1 << (HBITS - 1);
  localparam int NBYTES  = NBITS / 8;

  logic [NBITS-1:0] serialBits;
  logic [NBITS-1:0] serialSh;
  logic [NBITS-1:0] addrQ;
  logic             modeQ;
  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] crcNext;
  logic [HBITS-1:0] idxNext;
  logic             tableBit;
  logic [HALF_W-1:0] oneHot;

  // byte 0 sits in the top octet; bits inside a byte go out LSB first
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign serialBits[8*b + k] = addrIn[NBITS - 8*(b+1) + k];
    end
  end

  always_comb begin
    crcNext = crcQ >> 1;
    if (serialSh[0] ^ crcQ[0]) crcNext = crcNext ^ CRC_POLY;
    idxNext  = crcNext[CRC_W-1 -: HBITS];
    oneHot   = HALF_W'(1) << idxNext[HBITS-2:0];
    tableBit = idxNext[HBITS-1] ? tableHi[idxNext[HBITS-2:0]]
                                : tableLo[idxNext[HBITS-2:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serialSh  <= '0;
      addrQ     <= '0;
      modeQ     <= 1'b0;
      crcQ      <= CRC_INIT;
      hashIdx   <= '0;
      exactHit  <= 1'b0;
      hashHit   <= 1'b0;
      accept    <= 1'b0;
      progHi    <= '0;
      progLo    <= '0;
      physWord0 <= '0;
      physWord1 <= '0;
    end else begin
      if (strobes.load) begin
        serialSh <= serialBits;
        addrQ    <= addrIn;
        modeQ    <= progMode;
        crcQ     <= CRC_INIT;
      end else if (strobes.shift) begin
        serialSh <= serialSh >> 1;
        crcQ     <= crcNext;
      end
      if (strobes.finish) begin
        hashIdx <= idxNext;
        if (modeQ) begin
          progHi    <= idxNext[HBITS-1] ? oneHot : '0;
          progLo    <= idxNext[HBITS-1] ? '0 : oneHot;
          physWord0 <= addrQ[NBITS-1 -: 32];
          physWord1 <= {addrQ[15:0], PHYS_TAG};
          exactHit  <= 1'b0;
          hashHit   <= 1'b0;
          accept    <= 1'b0;
        end else begin
          exactHit <= (addrQ == stationAddr);
          hashHit  <= tableBit;
          accept   <= (addrQ == stationAddr) || tableBit;
        end
      end
    end
  end

  // R5
  prog_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && modeQ) |=> $countones({progHi, progLo}) == 1);
  // R9
  filter_keeps_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !modeQ) |=> $stable(progHi) && $stable(progLo) && $stable(physWord0));
  // R9
  prog_clears_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && modeQ) |=> !accept && !exactHit && !hashHit);
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
  import addr_hash_pkg::*;
#(
  parameter int NBITS = ADDR_BITS,
  parameter int HBITS = HASH_BITS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      progMode,
  input  logic [NBITS-1:0]          addrIn,
  input  logic [NBITS-1:0]          stationAddr,
  input  logic [(1<<(HBITS-1))-1:0] tableHi,
  input  logic [(1<<(HBITS-1))-1:0] tableLo,
  output logic                      busy,
  output logic                      done,
  output logic [HBITS-1:0]          hashIdx,
  output logic                      exactHit,
  output logic                      hashHit,
  output logic                      accept,
  output logic [(1<<(HBITS-1))-1:0] progHi,
  output logic [(1<<(HBITS-1))-1:0] progLo,
  output logic [31:0]               physWord0,
  output logic [31:0]               physWord1
);
  hashStrobe_t strobes;

  hash_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .busy(busy), .done(done)
  );

  hash_datapath #(.NBITS(NBITS), .HBITS(HBITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .progMode(progMode),
    .addrIn(addrIn), .stationAddr(stationAddr),
    .tableHi(tableHi), .tableLo(tableLo),
    .hashIdx(hashIdx), .exactHit(exactHit), .hashHit(hashHit),
    .accept(accept), .progHi(progHi), .progLo(progLo),
    .physWord0(physWord0), .physWord1(physWord1)
  );
endmodule

// File: tb/addr_hash_filter_tb.sv
module addr_hash_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        progMode = 1'b0;
  logic [47:0] addrIn = '0;
  logic [47:0] stationAddr = '0;
  logic [31:0] tableHi = '0;
  logic [31:0] tableLo = '0;
  logic        busy, done, exactHit, hashHit, accept;
  logic [5:0]  hashIdx;
  logic [31:0] progHi, progLo, physWord0, physWord1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  addr_hash_filter u_dut (
    .clk(clk), .rstN(rstN), .start(start), .progMode(progMode),
    .addrIn(addrIn), .stationAddr(stationAddr),
    .tableHi(tableHi), .tableLo(tableLo),
    .busy(busy), .done(done), .hashIdx(hashIdx),
    .exactHit(exactHit), .hashHit(hashHit), .accept(accept),
    .progHi(progHi), .progLo(progLo),
    .physWord0(physWord0), .physWord1(physWord1)
  );

  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] crc = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] cur = a[47 - 8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        if (cur[0] ^ crc[0]) crc = (crc >> 1) ^ 32'hEDB8_8320;
        else crc = crc >> 1;
        cur = cur >> 1;
      end
    end
    return crc[31:26];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; glitch raises a second start mid-run with another address
  task automatic runOp(input logic [47:0] a, input bit pm, input bit glitch);
    @(negedge clk);
    addrIn = a; progMode = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 47; c++) begin
      if (glitch && c == 9) begin start = 1'b1; addrIn = ~a; progMode = ~pm; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b0 && busy == 1'b1, "R3 early", {62'd0, done, busy}, 64'h1);
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R3 due", {62'd0, done, busy}, 64'h2);
  endtask

  task automatic doAddr(input logic [47:0] a, input bit glitch);
    logic [5:0]  e = refIdx(a);
    logic [31:0] eHi = e[5] ? (32'd1 << e[4:0]) : 32'd0;
    logic [31:0] eLo = e[5] ? 32'd0 : (32'd1 << e[4:0]);
    logic [31:0] keepHi, keepLo, keep0, keep1;
    // program mode: R2 R5 R6 R9
    runOp(a, 1'b1, glitch);
    chk(hashIdx == e, glitch ? "R4 idx" : "R2 idx", 64'(hashIdx), 64'(e));
    chk(progHi == eHi && progLo == eLo, "R5 onehot", {progHi, progLo}, {eHi, eLo});
    chk(physWord0 == a[47:16] && physWord1 == {a[15:0], 16'h8808}, "R6 packing",
        {physWord0, physWord1}, {a[47:16], a[15:0], 16'h8808});
    chk(!accept && !exactHit && !hashHit, "R9 prog clears", {61'd0, accept, exactHit, hashHit}, 64'd0);
    keepHi = progHi; keepLo = progLo; keep0 = physWord0; keep1 = physWord1;
    // filter, own bucket enabled, station differs: R8
    tableHi = eHi; tableLo = eLo; stationAddr = ~a;
    runOp(a, 1'b0, 1'b0);
    chk(hashHit && !exactHit && accept, "R8 hit", {61'd0, accept, exactHit, hashHit}, 64'h5);
    chk(progHi == keepHi && progLo == keepLo && physWord0 == keep0 && physWord1 == keep1,
        "R9 prog held", {progHi, progLo}, {keepHi, keepLo});
    // filter, every other bucket enabled, station equal: R7 R8
    tableHi = ~eHi; tableLo = ~eLo; stationAddr = a;
    runOp(a, 1'b0, 1'b0);
    chk(!hashHit && exactHit && accept, "R7 exact", {61'd0, accept, exactHit, hashHit}, 64'h6);
    // filter, every other bucket enabled, station differs: R8 reject
    stationAddr = a ^ 48'h1;
    runOp(a, 1'b0, 1'b0);
    chk(!hashHit && !exactHit && !accept, "R8 reject", {61'd0, accept, exactHit, hashHit}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !accept && !exactHit && !hashHit && hashIdx == 0 &&
        progHi == 0 && progLo == 0 && physWord0 == 0 && physWord1 == 0,
        "R1 reset", {busy, done, accept, hashIdx}, 64'd0);
    rstN = 1'b1;
    doAddr(48'h0, 1'b0);
    doAddr(48'hFFFF_FFFF_FFFF, 1'b0);
    doAddr(48'h0102_0304_0506, 1'b1);
    for (int i = 0; i < 48; i++) doAddr(48'd1 << i, 1'b0);
    for (int i = 0; i < 80; i++)
      doAddr(48'h0123_4567_89AB ^ (48'(i) * 48'h0000_9E37_79B9) ^ (48'(i) << 40), (i % 7) == 3);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule